// File: doc/BRIEF.md
# ATAPI Task-File Register Port

This block is the device end of an ATA/ATAPI host register port. The host selects a register with two active-low chip selects and a 3-bit address, then strobes an active-low read or write. The block holds a small task file: features, sector count, sector number, byte count, drive select, command and status, plus a device-control register. It gives the local controller the host's writes and a pulse for each command. Data-port writes collect a command packet of PKT_BYTES bytes, 12 by default, in a FIFO that the local controller drains. The block raises a pulse when the packet is complete.

Every host input is assumed already synchronised to `clk`. An access exists while exactly one chip select and exactly one strobe are low. If this device is selected but the local side reports that it is not ready, IORDY is held low to stretch the host cycle. The stretch ends when the local side becomes ready, or when a limit of STRETCH_MAX clocks is reached. The interrupt line is shown as a value and an output enable, so that a pad wrapper can build the tristate. The line is enabled only when this device is selected and interrupts are not disabled.

Top module: `atapi_taskfile_port`

## Requirements
- R1: An access exists when exactly one of cs0_n/cs1_n is low and exactly one of rd_n/wr_n is low. With cs0_n low, the address selects these registers:
  - 1: features (write) or error (read, returns loc_err).
  - 2: count.
  - 3: number.
  - 4: byte-count low.
  - 5: byte-count high.
  - 6: drive select.
  - 7: command (write) or status (read).

  With cs1_n low, address 6 is device control (write) or alternate status (read), and every other address reads 0. Read data is on dd_out with dd_oe high from one clock after the access is accepted until the strobe is released. The written features, count, number, byte count and drive-select values appear on the tf_* outputs.
- R2: Register writes use only dd_in[7:0], and register reads return 00h in dd_out[15:8]. cs0_n address 0 is the 16-bit data port: reads return loc_rdata, and writes go to the packet FIFO.
- R3: A data-port write pushes dd_in[7:0] and then dd_in[15:8] into a FIFO of PKT_BYTES bytes. pkt_byte shows the oldest byte, pkt_pop removes it, and pkt_level gives the fill. A write that would take the fill above PKT_BYTES is ignored in full.
- R4: pkt_ready is a one-clock pulse, high in the clock after the write that brings the fill to exactly PKT_BYTES.
- R5: Bit 4 of the drive-select register is compared with dev_id. While they differ, reads keep dd_oe low, IORDY stays high, and writes other than drive select and device control are ignored.
- R6: intrq_oe is high only when device-control bit 1 (interrupt disable) is 0 and the device is selected (R5). intrq_out carries the pending interrupt.
- R7: A loc_irq pulse sets the pending interrupt. A status read (cs0_n, address 7) clears it, and an alternate-status read leaves it set.
- R8: During an access to the selected device with dev_ready low, iordy is low. It goes high in the same clock that dev_ready rises, and the access completes at the next edge.
- R9: iordy is low for at most STRETCH_MAX-1 consecutive clocks of one access. After that the access completes as if the device were ready.
- R10: host_rst_n low at a clock edge clears the following:
  - device control, drive select, status, features and the pending interrupt;
  - the FIFO, which is emptied.

  It also sets count and number to 01h and byte count to EBh:14h (high:low).
- R11: While device-control bit 2 (soft reset) is set, the task file, the FIFO and the pending interrupt are held at their R10 values. Device control itself is not affected.
- R12: A command write (cs0_n, address 7) loads cmd_code, pulses cmd_valid in the next clock and sets status bit 7 (busy). loc_stat_we loads the whole status byte from loc_stat, and a command write in the same clock still sets bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| host_rst_n | input | 1 | Host hardware reset, active low, synchronous |
| cs0_n | input | 1 | Command-group chip select, active low |
| cs1_n | input | 1 | Control-group chip select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| dd_in | input | 16 | Host data into the device |
| dd_out | output | 16 | Read data to the host |
| dd_oe | output | 1 | Enable for dd_out |
| iordy | output | 1 | Low to stretch the host cycle |
| intrq_out | output | 1 | Pending interrupt value |
| intrq_oe | output | 1 | Enable for the interrupt pad |
| dev_id | input | 1 | Strapped device number |
| dev_ready | input | 1 | Local side can answer an access |
| loc_stat_we | input | 1 | Load the status register |
| loc_stat | input | 8 | Status value from the local side |
| loc_irq | input | 1 | Raise a host interrupt |
| loc_err | input | 8 | Error register value |
| loc_rdata | input | 16 | Data-port read value |
| pkt_pop | input | 1 | Remove the oldest packet byte |
| pkt_byte | output | 8 | Oldest packet byte |
| pkt_level | output | $clog2(PKT_BYTES+1) | Packet FIFO fill |
| pkt_ready | output | 1 | Pulse: packet complete |
| cmd_valid | output | 1 | Pulse: command written |
| cmd_code | output | 8 | Last command byte |
| tf_features | output | 8 | Features register |
| tf_count | output | 8 | Count register |
| tf_number | output | 8 | Number register |
| tf_bcount | output | 16 | Byte count, high:low |
| tf_devhead | output | 8 | Drive-select register |

## Verification
The bench builds the block with STRETCH_MAX set to 4 and PKT_BYTES left at 12. The small stretch limit lets the timeout of R9 be reached in three stalled clocks, next to a stretch that ends early because dev_ready rises. A 12-byte packet exercises the FIFO's wrap, the full condition and the rejected extra write within a handful of host cycles.

// File: rtl/atapi_taskfile_port.sv
module atapi_taskfile_port #(
  parameter int STRETCH_MAX = 64,
  parameter int PKT_BYTES   = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           host_rst_n,
  input  logic                           cs0_n,
  input  logic                           cs1_n,
  input  logic [2:0]                     addr,
  input  logic                           rd_n,
  input  logic                           wr_n,
  input  logic [15:0]                    dd_in,
  output logic [15:0]                    dd_out,
  output logic                           dd_oe,
  output logic                           iordy,
  output logic                           intrq_out,
  output logic                           intrq_oe,
  input  logic                           dev_id,
  input  logic                           dev_ready,
  input  logic                           loc_stat_we,
  input  logic [7:0]                     loc_stat,
  input  logic                           loc_irq,
  input  logic [7:0]                     loc_err,
  input  logic [15:0]                    loc_rdata,
  input  logic                           pkt_pop,
  output logic [7:0]                     pkt_byte,
  output logic [$clog2(PKT_BYTES+1)-1:0] pkt_level,
  output logic                           pkt_ready,
  output logic                           cmd_valid,
  output logic [7:0]                     cmd_code,
  output logic [7:0]                     tf_features,
  output logic [7:0]                     tf_count,
  output logic [7:0]                     tf_number,
  output logic [15:0]                    tf_bcount,
  output logic [7:0]                     tf_devhead
);
  localparam int LVL_W = $clog2(PKT_BYTES + 1);
  localparam int PTR_W = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;
  localparam int SC_W  = $clog2(STRETCH_MAX + 1);

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(PKT_BYTES - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [7:0]       status_q, devctl_q;
  logic             irq_q, done_q;
  logic [SC_W-1:0]  wait_q;
  logic [15:0]      rdat_q;
  logic [7:0]       mem [PKT_BYTES];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wp1;
  logic [15:0]      rmux;
  logic [LVL_W:0]   lvl_next;

  logic act, act_rd, act_wr, dev_match, limit, go, tf_clr;
  logic wr_go, rd_go, stat_rd, dh_wr, ctl_wr, push, pop;

  assign act       = (cs0_n ^ cs1_n) && (rd_n ^ wr_n);
  assign act_rd    = act && !rd_n;
  assign act_wr    = act && !wr_n;
  assign dev_match = (tf_devhead[4] == dev_id);
  assign limit     = (wait_q == SC_W'(STRETCH_MAX - 1));
  assign go        = act && !done_q && (!dev_match || dev_ready || limit);
  assign iordy     = !(act && !done_q && dev_match && !dev_ready && !limit);
  assign tf_clr    = !host_rst_n || devctl_q[2];

  assign wr_go   = go && act_wr && dev_match && !cs0_n;
  assign rd_go   = go && act_rd && dev_match;
  assign stat_rd = rd_go && !cs0_n && addr == 3'd7;
  assign dh_wr   = go && act_wr && !cs0_n && addr == 3'd6;
  assign ctl_wr  = go && act_wr && !cs1_n && addr == 3'd6;

  assign dd_oe     = act_rd && done_q && dev_match;
  assign dd_out    = rdat_q;
  assign intrq_oe  = !devctl_q[1] && dev_match;
  assign intrq_out = irq_q;

  always_comb begin
    rmux = 16'h0000;
    if (!cs0_n) begin
      case (addr)
        3'd0: rmux = loc_rdata;
        3'd1: rmux = {8'h00, loc_err};
        3'd2: rmux = {8'h00, tf_count};
        3'd3: rmux = {8'h00, tf_number};
        3'd4: rmux = {8'h00, tf_bcount[7:0]};
        3'd5: rmux = {8'h00, tf_bcount[15:8]};
        3'd6: rmux = {8'h00, tf_devhead};
        default: rmux = {8'h00, status_q};
      endcase
    end else if (addr == 3'd6) begin
      rmux = {8'h00, status_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wait_q <= '0;
      rdat_q <= '0;
    end else if (!act) begin
      done_q <= 1'b0;
      wait_q <= '0;
    end else if (go) begin
      done_q <= 1'b1;
      wait_q <= '0;
      if (act_rd) rdat_q <= rmux;
    end else if (!done_q) begin
      wait_q <= wait_q + SC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           devctl_q <= '0;
    else if (!host_rst_n) devctl_q <= '0;
    else if (ctl_wr)      devctl_q <= dd_in[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf_features <= '0;    tf_count   <= 8'h01; tf_number <= 8'h01;
      tf_bcount   <= 16'hEB14; tf_devhead <= '0;  status_q  <= '0;
      irq_q       <= 1'b0;  cmd_code   <= '0;    cmd_valid <= 1'b0;
    end else if (tf_clr) begin
      tf_features <= '0;    tf_count   <= 8'h01; tf_number <= 8'h01;
      tf_bcount   <= 16'hEB14; tf_devhead <= '0;  status_q  <= '0;
      irq_q       <= 1'b0;  cmd_valid  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (loc_stat_we) status_q <= loc_stat;
      if (wr_go) begin
        case (addr)
          3'd1: tf_features     <= dd_in[7:0];
          3'd2: tf_count        <= dd_in[7:0];
          3'd3: tf_number       <= dd_in[7:0];
          3'd4: tf_bcount[7:0]  <= dd_in[7:0];
          3'd5: tf_bcount[15:8] <= dd_in[7:0];
          3'd7: begin
            cmd_code    <= dd_in[7:0];
            cmd_valid   <= 1'b1;
            status_q[7] <= 1'b1;
          end
          default: ;
        endcase
      end
      if (dh_wr) tf_devhead <= dd_in[7:0];
      if (loc_irq)      irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
    end
  end

  assign wp1      = wrap_inc(wr_ptr);
  assign push     = wr_go && addr == 3'd0 && pkt_level <= LVL_W'(PKT_BYTES - 2);
  assign pop      = pkt_pop && pkt_level != '0;
  assign lvl_next = {1'b0, pkt_level} + (push ? (LVL_W+1)'(2) : '0) - (pop ? (LVL_W+1)'(1) : '0);
  assign pkt_byte = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; pkt_level <= '0; pkt_ready <= 1'b0;
    end else if (tf_clr) begin
      wr_ptr <= '0; rd_ptr <= '0; pkt_level <= '0; pkt_ready <= 1'b0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wp1);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      pkt_level <= lvl_next[LVL_W-1:0];
      pkt_ready <= push && (lvl_next == (LVL_W+1)'(PKT_BYTES));
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= dd_in[7:0];
      mem[wp1]    <= dd_in[15:8];
    end
  end

  AST_IORDY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !iordy |-> (act && dev_match)); // R8
  AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !iordy |-> (wait_q < SC_W'(STRETCH_MAX - 1))); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_level <= LVL_W'(PKT_BYTES)); // R3
  AST_PKT_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |=> !pkt_ready); // R4
  AST_OE_ON_SELECTED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> (!rd_n && dev_match)); // R5
  AST_NIEN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    devctl_q[1] |-> !intrq_oe); // R6
  AST_STATUS_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !loc_irq) |=> !intrq_out); // R7
  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> status_q[7]); // R12
endmodule

// File: tb/atapi_taskfile_port_bench.sv
module atapi_taskfile_port_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, host_rst_n, cs0_n, cs1_n, rd_n, wr_n;
  logic [2:0] addr;
  logic [15:0] dd_in, dd_out, loc_rdata, tf_bcount;
  logic dd_oe, iordy, intrq_out, intrq_oe, dev_id, dev_ready;
  logic loc_stat_we, loc_irq, pkt_pop, pkt_ready, cmd_valid;
  logic [7:0] loc_stat, loc_err, pkt_byte, cmd_code, tf_features, tf_count, tf_number, tf_devhead;
  logic [3:0] pkt_level;

  atapi_taskfile_port #(.STRETCH_MAX(4), .PKT_BYTES(12)) u_atapi_taskfile_port (
    .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
    .iordy(iordy), .intrq_out(intrq_out), .intrq_oe(intrq_oe), .dev_id(dev_id),
    .dev_ready(dev_ready), .loc_stat_we(loc_stat_we), .loc_stat(loc_stat), .loc_irq(loc_irq),
    .loc_err(loc_err), .loc_rdata(loc_rdata), .pkt_pop(pkt_pop), .pkt_byte(pkt_byte),
    .pkt_level(pkt_level), .pkt_ready(pkt_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .tf_features(tf_features), .tf_count(tf_count), .tf_number(tf_number),
    .tf_bcount(tf_bcount), .tf_devhead(tf_devhead));

  int total = 0;
  int bad = 0;
  logic [15:0] r_data;
  logic r_oe, r_pkt, r_cmd, r_intrq;
  int r_waits;

  // {write, cs1, addr[2:0], data[15:0], expected read[15:0]}
  localparam logic [36:0] VEC [0:12] = '{
    {1'b1, 1'b0, 3'd2, 16'hFFA5, 16'h0000},
    {1'b1, 1'b0, 3'd3, 16'h005A, 16'h0000},
    {1'b1, 1'b0, 3'd4, 16'h0034, 16'h0000},
    {1'b1, 1'b0, 3'd5, 16'h0012, 16'h0000},
    {1'b0, 1'b0, 3'd2, 16'h0000, 16'h00A5},
    {1'b0, 1'b0, 3'd3, 16'h0000, 16'h005A},
    {1'b0, 1'b0, 3'd4, 16'h0000, 16'h0034},
    {1'b0, 1'b0, 3'd5, 16'h0000, 16'h0012},
    {1'b1, 1'b0, 3'd6, 16'h00E0, 16'h0000},
    {1'b0, 1'b0, 3'd6, 16'h0000, 16'h00E0},
    {1'b0, 1'b0, 3'd1, 16'h0000, 16'h003C},
    {1'b0, 1'b0, 3'd0, 16'h0000, 16'hBEEF},
    {1'b0, 1'b1, 3'd6, 16'h0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic host_op(input bit wr, input bit c1, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs0_n = c1; cs1_n = !c1; addr = a; dd_in = d; wr_n = !wr; rd_n = wr;
    #1;
    r_waits = 0;
    while (!iordy) begin
      @(negedge clk); #1;
      r_waits++;
    end
    @(negedge clk); #1;
    r_data = dd_out; r_oe = dd_oe; r_pkt = pkt_ready; r_cmd = cmd_valid; r_intrq = intrq_out;
    cs0_n = 1'b1; cs1_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic loc_pulse_irq();
    @(negedge clk); loc_irq = 1'b1;
    @(negedge clk); loc_irq = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog (all requirements): got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_rst_n = 1'b1; cs0_n = 1'b1; cs1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; dd_in = '0; dev_id = 1'b0; dev_ready = 1'b1; loc_stat_we = 1'b0;
    loc_stat = '0; loc_irq = 1'b0; loc_err = 8'h3C; loc_rdata = 16'hBEEF; pkt_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset oe", 32'(dd_oe), 0);
    chk("R8 reset iordy", 32'(iordy), 1);
    chk("R6 reset intrq_oe", 32'(intrq_oe), 1);
    chk("R7 reset intrq", 32'(intrq_out), 0);
    chk("R3 reset level", 32'(pkt_level), 0);
    host_op(0, 0, 3'd4, 0); chk("R10 signature low", 32'(r_data), 32'h14);
    host_op(0, 0, 3'd5, 0); chk("R10 signature high", 32'(r_data), 32'hEB);

    for (int i = 0; i < 13; i++) begin
      host_op(VEC[i][36], VEC[i][35], VEC[i][34:32], VEC[i][31:16]);
      if (!VEC[i][36]) begin
        chk("R1 vector oe", 32'(r_oe), 1);
        chk("R1 vector data", 32'(r_data), 32'(VEC[i][15:0]));
      end
    end
    chk("R2 upper byte dropped", 32'(tf_count), 32'hA5);
    host_op(1, 0, 3'd1, 16'h0077);
    chk("R1 features out", 32'(tf_features), 32'h77);

    host_op(1, 0, 3'd7, 16'h00A0);
    chk("R12 cmd_valid", 32'(r_cmd), 1);
    chk("R12 cmd_code", 32'(cmd_code), 32'hA0);
    host_op(0, 1, 3'd6, 0); chk("R12 busy set", 32'(r_data), 32'h80);
    @(negedge clk); loc_stat = 8'h48; loc_stat_we = 1'b1;
    @(negedge clk); loc_stat_we = 1'b0;
    host_op(0, 1, 3'd6, 0); chk("R12 local status load", 32'(r_data), 32'h48);

    for (int i = 0; i < 6; i++) begin
      host_op(1, 0, 3'd0, {8'(2*i+2), 8'(2*i+1)});
      chk("R4 packet ready pulse", 32'(r_pkt), (i == 5) ? 1 : 0);
    end
    chk("R3 full level", 32'(pkt_level), 12);
    host_op(1, 0, 3'd0, 16'hFFFF);
    chk("R3 overfull write ignored", 32'(pkt_level), 12);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1;
      chk("R3 packet order", 32'(pkt_byte), 32'(i + 1));
      pkt_pop = 1'b1;
    end
    @(negedge clk); pkt_pop = 1'b0; #1;
    chk("R3 drained", 32'(pkt_level), 0);

    dev_ready = 1'b0;
    @(negedge clk);
    cs0_n = 1'b0; cs1_n = 1'b1; addr = 3'd3; rd_n = 1'b0; wr_n = 1'b1; #1;
    chk("R8 stretch", 32'(iordy), 0);
    @(negedge clk); #1;
    chk("R8 still stretched", 32'(iordy), 0);
    dev_ready = 1'b1; #1;
    chk("R8 release on ready", 32'(iordy), 1);
    @(negedge clk); #1;
    chk("R8 data after stretch", 32'({dd_oe, dd_out}), 32'h1005A);
    cs0_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
    host_op(0, 0, 3'd3, 0);
    chk("R9 stretch limit", r_waits, 3);
    chk("R9 completes at limit", 32'({r_oe, r_data}), 32'h1005A);
    dev_ready = 1'b1;

    loc_pulse_irq();
    chk("R7 irq pending", 32'(intrq_out), 1);
    host_op(0, 1, 3'd6, 0); chk("R7 alt status keeps irq", 32'(r_intrq), 1);
    host_op(0, 0, 3'd7, 0); chk("R7 status clears irq", 32'(r_intrq), 0);
    chk("R7 status value", 32'(r_data), 32'h48);

    host_op(1, 1, 3'd6, 16'h0002); #1;
    chk("R6 disabled hi-z", 32'(intrq_oe), 0);
    loc_pulse_irq();
    chk("R6 pending while hi-z", 32'({intrq_oe, intrq_out}), 32'h1);
    host_op(1, 1, 3'd6, 16'h0000); #1;
    chk("R6 re-enabled", 32'(intrq_oe), 1);
    host_op(0, 0, 3'd7, 0);

    host_op(1, 0, 3'd6, 16'h0010); #1;
    chk("R5 unselected hi-z", 32'(intrq_oe), 0);
    dev_ready = 1'b0;
    host_op(0, 0, 3'd7, 0);
    chk("R5 no stretch", r_waits, 0);
    chk("R5 no drive", 32'(r_oe), 0);
    host_op(1, 0, 3'd2, 16'h0033);
    dev_ready = 1'b1;
    host_op(1, 0, 3'd6, 16'h0000);
    host_op(0, 0, 3'd2, 0);
    chk("R5 write ignored", 32'(r_data), 32'hA5);

    host_op(1, 0, 3'd4, 16'h0077);
    host_op(1, 0, 3'd0, 16'h1234);
    host_op(1, 1, 3'd6, 16'h0004);
    host_op(1, 1, 3'd6, 16'h0000);
    chk("R11 fifo flushed", 32'(pkt_level), 0);
    host_op(0, 0, 3'd4, 0); chk("R11 signature restored", 32'(r_data), 32'h14);
    host_op(0, 1, 3'd6, 0); chk("R11 status cleared", 32'(r_data), 0);

    host_op(1, 1, 3'd6, 16'h0002);
    host_op(1, 0, 3'd3, 16'h0099);
    @(negedge clk); host_rst_n = 1'b0;
    @(negedge clk); host_rst_n = 1'b1; #1;
    chk("R10 control cleared", 32'(intrq_oe), 1);
    host_op(0, 0, 3'd3, 0); chk("R10 number reset", 32'(r_data), 32'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule